// File: doc/BRIEF.md
# Block Archiver with CRC Integrity

This block collects acquired sample bytes into fixed-size blocks and hands each finished block to a serializer on the storage side. That serializer drives a detachable flash card. Two staging buffers alternate roles. One fills from the sample stream while the other drains toward storage. A block is only offered for writing once its buffer holds every byte. Each block is followed by a 16-bit CRC, computed while the payload streams out.

Writes are gated on the card being present and initialised. When the card is detected, the block raises an initialisation request. It holds that request until the storage side confirms, and only then does it accept samples. If the card is removed during a write, the write is aborted. All staged data is thrown away and initialisation must be repeated.

A mode input selects between two ways of writing. In single-block mode, every block gets its own start command. In multi-block mode, blocks that are already staged follow one another after a single start, and a stop pulse closes the run. A 32-bit count of committed blocks advances only on an error-free completion. That count is also the sequence number of the block currently in flight.

Top module: `blk_archiver`

## Requirements
- R1: `s_ready_o` stays low until the card is present and `init_done_i` has been seen. `init_req_o` is high while the card is present but not yet initialised, and `card_ok_o` is high only once initialisation is complete.
- R2: No write starts unless `card_ok_o` is high and a complete block of `BLK_BYTES` bytes is staged. A partly filled buffer produces no activity on the storage port.
- R3: `st_start_o` is a one-cycle pulse. It is raised only if `st_busy_i` was low in the cycle before.
- R4: After a start, the storage port carries the `BLK_BYTES` payload bytes in arrival order, then the CRC high byte, then the CRC low byte. Each byte transfers in a cycle where both `st_valid_o` and `st_ready_i` are high.
- R5: The CRC uses polynomial 0x1021 with initial value 0xFFFF. It is computed MSB-first over the payload bytes, with no reflection and no final XOR.
- R6: A `st_done_i` with `st_err_i` low increments `commit_cnt_o` by one. A `st_done_i` with `st_err_i` high discards the block and leaves the count unchanged, and `drop_o` pulses in the following cycle.
- R7: Two blocks can be staged at once. While both buffers are full, `s_ready_o` is low.
- R8: With `multi_mode_i` high, a block that is staged when the previous block completes is streamed without a new `st_start_o`. `st_stop_o` pulses once when the run ends.
- R9: If `card_present_i` drops during a write, `st_abort_o` is raised in that cycle. From the next cycle, `st_valid_o`, `card_ok_o` and `s_ready_o` are low and all staged data is discarded. The count is unchanged, and a new initialisation is required.
- R10: While `st_valid_o` is high and `st_ready_i` is low, with the card present, `st_valid_o` and `st_data_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| multi_mode_i | input | 1 | 1 selects multi-block streaming |
| s_data_i | input | 8 | Sample byte |
| s_valid_i | input | 1 | Sample byte valid |
| s_ready_o | output | 1 | Sample byte accepted when high with valid |
| card_present_i | input | 1 | Card detect |
| init_req_o | output | 1 | Request to initialise the card |
| init_done_i | input | 1 | Initialisation complete |
| card_ok_o | output | 1 | Card present and initialised |
| st_busy_i | input | 1 | Storage serializer busy |
| st_start_o | output | 1 | Start of a block write command |
| st_data_o | output | 8 | Byte toward storage |
| st_valid_o | output | 1 | Byte toward storage valid |
| st_ready_i | input | 1 | Storage accepts the byte |
| st_done_i | input | 1 | Storage reports a block finished |
| st_err_i | input | 1 | Error qualifier for done |
| st_stop_o | output | 1 | End of a multi-block run |
| st_abort_o | output | 1 | Current write aborted on card loss |
| commit_cnt_o | output | 32 | Committed blocks; sequence of block in flight |
| drop_o | output | 1 | Pulse: block discarded after storage error |

## Verification
Some properties are checked on every cycle:
- ready and valid only appear with an initialised card;
- start pulses are one cycle long and respect busy;
- the committed count moves only by one, and only after an error-free done;
- drops follow failed completions;
- storage-side data holds under back-pressure;
- an abort clears the write path.

Other behaviours can only be shown by the directed scenarios:
- the actual payload order and CRC values;
- the absence of any write for a partial block;
- the reuse of a single start across a multi-block run;
- the discarding of stale data after a removal and re-initialisation.

// File: rtl/blk_arch_pkg.sv
package blk_arch_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [1:0] {CD_ABSENT, CD_INIT, CD_READY} card_st_e;

  typedef enum logic [2:0] {
    WR_IDLE, WR_START, WR_DATA, WR_CRC_HI, WR_CRC_LO, WR_WAIT, WR_STOP
  } wr_st_e;

  // one byte, MSB first, no reflection
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/arch_card_ctl.sv
module arch_card_ctl
  import blk_arch_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic present_i,
  input  logic init_done_i,
  output logic init_req_o,
  output logic ok_o
);

  card_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CD_ABSENT: if (present_i) st_d = CD_INIT;
      CD_INIT:   if (!present_i) st_d = CD_ABSENT;
                 else if (init_done_i) st_d = CD_READY;
      CD_READY:  if (!present_i) st_d = CD_ABSENT;
      default:   st_d = CD_ABSENT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= CD_ABSENT;
    else         st_q <= st_d;
  end

  assign init_req_o = (st_q == CD_INIT);
  assign ok_o       = (st_q == CD_READY);

endmodule

// File: rtl/arch_crc16.sv
module arch_crc16
  import blk_arch_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);

  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= CRC_SEED;
    else if (clr_i) crc_q <= CRC_SEED;
    else if (en_i)  crc_q <= crc_step(crc_q, byte_i);
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/arch_stage_buf.sv
module arch_stage_buf #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             en_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_full_o,
  output logic             nxt_full_o,
  input  logic             release_i
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [7:0]       mem [2][DEPTH];
  logic [1:0]       full_q;
  logic             wsel_q, rsel_q;
  logic [IDX_W-1:0] widx_q;
  logic             acc;

  assign in_ready_o = en_i && !full_q[wsel_q];
  assign acc        = in_ready_o && in_valid_i && !flush_i;

  // one bank per staging buffer
  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk_i) begin
      if (acc && (wsel_q == 1'(b))) mem[b][widx_q] <= in_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      wsel_q <= 1'b0;
      rsel_q <= 1'b0;
      widx_q <= '0;
    end else if (flush_i) begin
      full_q <= '0;
      wsel_q <= 1'b0;
      rsel_q <= 1'b0;
      widx_q <= '0;
    end else begin
      if (acc) begin
        if (widx_q == LAST_IDX) begin
          widx_q         <= '0;
          wsel_q         <= ~wsel_q;
          full_q[wsel_q] <= 1'b1;
        end else begin
          widx_q <= widx_q + 1'b1;
        end
      end
      if (release_i) begin
        full_q[rsel_q] <= 1'b0;
        rsel_q         <= ~rsel_q;
      end
    end
  end

  assign rd_data_o  = mem[rsel_q][rd_idx_i];
  assign rd_full_o  = full_q[rsel_q];
  assign nxt_full_o = full_q[~rsel_q];

endmodule

// File: rtl/blk_archiver.sv
module blk_archiver
  import blk_arch_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int CNT_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             multi_mode_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic             card_present_i,
  output logic             init_req_o,
  input  logic             init_done_i,
  output logic             card_ok_o,
  input  logic             st_busy_i,
  output logic             st_start_o,
  output logic [7:0]       st_data_o,
  output logic             st_valid_o,
  input  logic             st_ready_i,
  input  logic             st_done_i,
  input  logic             st_err_i,
  output logic             st_stop_o,
  output logic             st_abort_o,
  output logic [CNT_W-1:0] commit_cnt_o,
  output logic             drop_o
);

  localparam int IDX_W = $clog2(BLK_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

  wr_st_e           st_q, st_d;
  logic [IDX_W-1:0] ridx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             drop_q;
  logic             crc_clr, crc_en, rel, commit, drop_d;
  logic             rd_full, nxt_full;
  logic [7:0]       rd_data;
  logic [15:0]      crc;
  logic             in_write;

  arch_card_ctl u_card (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .present_i   (card_present_i),
    .init_done_i (init_done_i),
    .init_req_o  (init_req_o),
    .ok_o        (card_ok_o)
  );

  arch_stage_buf #(.DEPTH(BLK_BYTES)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (!card_present_i),
    .en_i       (card_ok_o),
    .in_data_i  (s_data_i),
    .in_valid_i (s_valid_i),
    .in_ready_o (s_ready_o),
    .rd_idx_i   (ridx_q),
    .rd_data_o  (rd_data),
    .rd_full_o  (rd_full),
    .nxt_full_o (nxt_full),
    .release_i  (rel)
  );

  arch_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (crc_en),
    .byte_i (rd_data),
    .crc_o  (crc)
  );

  assign in_write   = (st_q == WR_START) || (st_q == WR_DATA) || (st_q == WR_CRC_HI) ||
                      (st_q == WR_CRC_LO) || (st_q == WR_WAIT);
  assign st_abort_o = in_write && !card_present_i;

  always_comb begin
    st_d    = st_q;
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    rel     = 1'b0;
    commit  = 1'b0;
    drop_d  = 1'b0;
    if (st_abort_o) begin
      st_d = WR_IDLE;
    end else begin
      unique case (st_q)
        WR_IDLE:   if (card_ok_o && rd_full && !st_busy_i) st_d = WR_START;
        WR_START:  begin st_d = WR_DATA; crc_clr = 1'b1; end
        WR_DATA:   if (st_ready_i) begin
                     crc_en = 1'b1;
                     if (ridx_q == LAST_IDX) st_d = WR_CRC_HI;
                   end
        WR_CRC_HI: if (st_ready_i) st_d = WR_CRC_LO;
        WR_CRC_LO: if (st_ready_i) st_d = WR_WAIT;
        WR_WAIT:   if (st_done_i) begin
                     rel    = 1'b1;
                     commit = !st_err_i;
                     drop_d = st_err_i;
                     // continue the run only on a clean completion with a block staged
                     if (multi_mode_i && !st_err_i && nxt_full) begin
                       st_d    = WR_DATA;
                       crc_clr = 1'b1;
                     end else if (multi_mode_i) begin
                       st_d = WR_STOP;
                     end else begin
                       st_d = WR_IDLE;
                     end
                   end
        WR_STOP:   st_d = WR_IDLE;
        default:   st_d = WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WR_IDLE;
      ridx_q <= '0;
      cnt_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      drop_q <= drop_d;
      if (commit) cnt_q <= cnt_q + 1'b1;
      if (crc_clr || st_abort_o) ridx_q <= '0;
      else if (crc_en)           ridx_q <= ridx_q + 1'b1;
    end
  end

  always_comb begin
    unique case (st_q)
      WR_DATA:   st_data_o = rd_data;
      WR_CRC_HI: st_data_o = crc[15:8];
      WR_CRC_LO: st_data_o = crc[7:0];
      default:   st_data_o = 8'h00;
    endcase
  end

  assign st_valid_o   = (st_q == WR_DATA) || (st_q == WR_CRC_HI) || (st_q == WR_CRC_LO);
  assign st_start_o   = (st_q == WR_START);
  assign st_stop_o    = (st_q == WR_STOP);
  assign commit_cnt_o = cnt_q;
  assign drop_o       = drop_q;

endmodule

// File: rtl/blk_archiver_chk.sv
module blk_archiver_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             s_ready_o,
  input logic             card_present_i,
  input logic             init_req_o,
  input logic             card_ok_o,
  input logic             st_busy_i,
  input logic             st_start_o,
  input logic [7:0]       st_data_o,
  input logic             st_valid_o,
  input logic             st_ready_i,
  input logic             st_done_i,
  input logic             st_err_i,
  input logic             st_abort_o,
  input logic [CNT_W-1:0] commit_cnt_o,
  input logic             drop_o
);

  // R1
  ready_needs_card_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> card_ok_o);

  // R1
  init_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_o |-> !card_ok_o);

  // R3
  start_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_start_o |-> $past(!st_busy_i));

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_start_o |=> !st_start_o);

  // R6
  commit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_cnt_o != $past(commit_cnt_o)) |->
      ($past(st_done_i && !st_err_i) && (commit_cnt_o == $past(commit_cnt_o) + 1'b1)));

  // R6
  drop_after_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> $past(st_done_i && st_err_i));

  // R10
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_o && !st_ready_i && card_present_i) |=> (st_valid_o && $stable(st_data_o)));

  // R9
  valid_needs_card_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o |-> card_ok_o);

  // R9
  abort_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_abort_o |=> (!st_valid_o && !card_ok_o && !s_ready_o));

endmodule

bind blk_archiver blk_archiver_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_blk_archiver.sv
module sim_blk_archiver;

  localparam int BLK = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        multi_mode_i = 1'b0;
  logic [7:0]  s_data_i = '0;
  logic        s_valid_i = 1'b0;
  logic        s_ready_o;
  logic        card_present_i = 1'b0;
  logic        init_req_o;
  logic        init_done_i = 1'b0;
  logic        card_ok_o;
  logic        st_busy_i = 1'b0;
  logic        st_start_o;
  logic [7:0]  st_data_o;
  logic        st_valid_o;
  logic        st_ready_i = 1'b1;
  logic        st_done_i = 1'b0;
  logic        st_err_i = 1'b0;
  logic        st_stop_o;
  logic        st_abort_o;
  logic [31:0] commit_cnt_o;
  logic        drop_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] rx [256];
  int rx_n = 0, n_start = 0, n_stop = 0, n_abort = 0;

  always #2 clk_i = ~clk_i;

  blk_archiver #(.BLK_BYTES(BLK)) u0 (.*);

  always @(posedge clk_i) begin
    if (st_valid_o && st_ready_i) begin
      rx[rx_n[7:0]] <= st_data_o;
      rx_n <= rx_n + 1;
    end
    if (st_start_o) n_start <= n_start + 1;
    if (st_stop_o)  n_stop  <= n_stop + 1;
    if (st_abort_o) n_abort <= n_abort + 1;
  end

  function automatic logic [15:0] crc_ref(input logic [7:0] base, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = base + 8'(i);
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ d[b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic push_bytes(input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      s_data_i  = base + 8'(i);
      s_valid_i = 1'b1;
      while (!s_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    s_valid_i = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    while (rx_n < n) @(negedge clk_i);
  endtask

  task automatic give_done(input bit err);
    @(negedge clk_i);
    st_done_i = 1'b1;
    st_err_i  = err;
    @(negedge clk_i);
    st_done_i = 1'b0;
    st_err_i  = 1'b0;
  endtask

  task automatic check_frame(input int at, input logic [7:0] base, input string req);
    logic [15:0] c = crc_ref(base, BLK);
    bit ok = 1;
    for (int i = 0; i < BLK; i++) if (rx[at + i] !== base + 8'(i)) ok = 0;
    check(ok, req, rx[at], base);
    check(rx[at + BLK] === c[15:8] && rx[at + BLK + 1] === c[7:0], "R5 crc",
          {rx[at + BLK], rx[at + BLK + 1]}, c);
  endtask

  task automatic init_card();
    card_present_i = 1'b1;
    cycles(2);
    check(init_req_o === 1'b1, "R1 init_req", init_req_o, 1);
    check(s_ready_o === 1'b0, "R1 ready before init", s_ready_o, 0);
    init_done_i = 1'b1;
    @(negedge clk_i);
    init_done_i = 1'b0;
    @(negedge clk_i);
    check(card_ok_o === 1'b1 && init_req_o === 1'b0, "R1 card_ok", card_ok_o, 1);
    check(s_ready_o === 1'b1, "R1 ready after init", s_ready_o, 1);
  endtask

  task automatic t_reset();
    check(s_ready_o === 1'b0 && card_ok_o === 1'b0, "R1 reset ready", s_ready_o, 0);
    check(init_req_o === 1'b0, "R1 reset init_req", init_req_o, 0);
    check(st_valid_o === 1'b0 && commit_cnt_o === 32'd0, "R2 reset idle", commit_cnt_o, 0);
  endtask

  task automatic t_single();
    int b0 = rx_n, s0 = n_start;
    push_bytes(8'h10, BLK);
    wait_rx(b0 + BLK + 2);
    check(n_start == s0 + 1, "R3 one start", n_start - s0, 1);
    check_frame(b0, 8'h10, "R4 payload order");
    give_done(1'b0);
    check(commit_cnt_o === 32'd1, "R6 commit", commit_cnt_o, 1);
    check(drop_o === 1'b0, "R6 no drop", drop_o, 0);
  endtask

  task automatic t_partial_then_err();
    int b0 = rx_n, s0 = n_start;
    push_bytes(8'h40, 5);
    cycles(30);
    check(st_valid_o === 1'b0 && rx_n == b0, "R2 partial held", rx_n - b0, 0);
    check(n_start == s0, "R2 no start", n_start - s0, 0);
    push_bytes(8'h45, BLK - 5);
    wait_rx(b0 + BLK + 2);
    check_frame(b0, 8'h40, "R4 completed block");
    give_done(1'b1);
    check(commit_cnt_o === 32'd1, "R6 err keeps count", commit_cnt_o, 1);
    check(drop_o === 1'b1, "R6 drop pulse", drop_o, 1);
  endtask

  task automatic t_multi();
    int b0 = rx_n, s0 = n_start, p0 = n_stop;
    st_busy_i    = 1'b1;
    multi_mode_i = 1'b1;
    push_bytes(8'h60, BLK);
    push_bytes(8'h70, BLK);
    cycles(2);
    check(s_ready_o === 1'b0, "R7 both full", s_ready_o, 0);
    check(n_start == s0, "R3 busy blocks start", n_start - s0, 0);
    st_busy_i = 1'b0;
    wait_rx(b0 + BLK + 2);
    give_done(1'b0);
    wait_rx(b0 + 2 * (BLK + 2));
    check(n_start == s0 + 1, "R8 single start", n_start - s0, 1);
    check_frame(b0 + BLK + 2, 8'h70, "R8 second block");
    give_done(1'b0);
    cycles(2);
    check(n_stop == p0 + 1, "R8 stop", n_stop - p0, 1);
    check(commit_cnt_o === 32'd3, "R6 multi commits", commit_cnt_o, 3);
    multi_mode_i = 1'b0;
  endtask

  task automatic t_abort();
    int a0 = n_abort, b0;
    logic [7:0] held;
    st_ready_i = 1'b0;
    push_bytes(8'h90, BLK);
    while (!st_valid_o) @(negedge clk_i);
    st_ready_i = 1'b1;
    cycles(3);
    st_ready_i = 1'b0;
    @(negedge clk_i);
    held = st_data_o;
    @(negedge clk_i);
    check(st_valid_o === 1'b1 && st_data_o === held, "R10 hold", st_data_o, held);
    card_present_i = 1'b0;
    @(negedge clk_i);
    check(n_abort == a0 + 1, "R9 abort", n_abort - a0, 1);
    check(st_valid_o === 1'b0 && card_ok_o === 1'b0 && s_ready_o === 1'b0,
          "R9 cleared", card_ok_o, 0);
    check(commit_cnt_o === 32'd3, "R9 count kept", commit_cnt_o, 3);
    st_ready_i = 1'b1;
    init_card();
    b0 = rx_n;
    push_bytes(8'hA0, BLK);
    wait_rx(b0 + BLK + 2);
    check_frame(b0, 8'hA0, "R9 stale flushed");
    give_done(1'b0);
    check(commit_cnt_o === 32'd4, "R6 commit after reinit", commit_cnt_o, 4);
  endtask

  initial begin
    cycles(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    init_card();
    t_single();
    t_partial_then_err();
    t_multi();
    t_abort();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule